// File: doc/BRIEF.md
# SPI Master Control and Slave-Select Slice

This block is the register and control portion of an SPI master. A host writes and reads two registers over a simple single-cycle memory-mapped port. The first is a control word that holds interrupt enables and a force-select bit. The second is a slave-select mask. The block does not shift any data. A separate shift engine supplies four status flags and a busy indication. The block combines those inputs with the two registers to produce one level-sensitive interrupt request and the active-low slave-select lines.

The mask may have several bits set at once, so one transaction can address several slaves together. The mask leaves reset with only slave 0 chosen. When the force-select bit is set, the chosen lines stay asserted while the shift engine is idle between words. The host can therefore frame transfers that are longer than one word.

Top module: `spim_ctl_slice`

## Requirements
- R1: After reset, the control register reads 0, the select register reads 1 (only slave 0 chosen), `irq` is low and every `ss_n` line is high.
- R2: A write to address 0 stores only the defined control bits: 3, 4, 6, 7, 8 and 10. Every other control bit reads back as 0. The new value is visible on the cycle after the write edge.
- R3: A write to address 1 stores the low NSS bits as the select mask. Bits above NSS read back as 0.
- R4: A register keeps its value when the host does not write it. A write to one address leaves the other register unchanged. A write to any address other than 0 or 1 changes neither register, and a read from such an address returns 0.
- R5: `irq` is high when an individual enable and its flag are both 1. The pairs are: bit 3 with receive overrun, bit 4 with transmit overrun, bit 6 with transmitter ready, and bit 7 with receiver ready.
- R6: When control bit 8 (any-error enable) is 1, either overrun flag raises `irq`, even if bits 3 and 4 are 0.
- R7: `irq` is low whenever no enabled condition is set. This includes the case where flags are set but their enables are 0.
- R8: While `shift_busy` is 1, `ss_n[i]` is low exactly when mask bit i is 1.
- R9: When control bit 10 (force-select) is 1, the masked `ss_n` lines are low even when `shift_busy` is 0.
- R10: When `shift_busy` is 0 and force-select is 0, every `ss_n` line is high, whatever the mask holds.
- R11: When several mask bits are set, all of the corresponding `ss_n` lines go low together, and the unselected lines stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | ADDR_W | Register address (0 control, 1 select) |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Combinational read data for `host_addr` |
| st_rx_ovr | input | 1 | Receive overrun flag |
| st_tx_ovr | input | 1 | Transmit overrun flag |
| st_tx_rdy | input | 1 | Transmitter ready flag |
| st_rx_rdy | input | 1 | Receiver ready flag |
| shift_busy | input | 1 | Shift engine has a word in progress |
| irq | output | 1 | Level interrupt request |
| ss_n | output | NSS | Active-low slave selects |

## Verification
The assertions assume the status flags and `shift_busy` are steady levels around each clock edge. They also assume the host holds `host_wr` low for the whole reset period, so the register-hold properties have a clean first cycle. The stimulus meets both assumptions by changing every input on the falling edge and by starting host writes only after reset is released. The bench reads registers and samples `irq` and `ss_n` combinationally, one time unit after each falling-edge change.

// File: rtl/spim_ctl_pkg.sv
package spim_ctl_pkg;
  localparam int CTRL_W  = 11;
  localparam int B_IROVR = 3;
  localparam int B_ITOVR = 4;
  localparam int B_ITRDY = 6;
  localparam int B_IRRDY = 7;
  localparam int B_IERR  = 8;
  localparam int B_FSEL  = 10;
  localparam logic [CTRL_W-1:0] CTRL_MASK = 11'b101_1101_1000;
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_SEL  = 1;

  // Keep only the defined control bits of a host write.
  function automatic logic [CTRL_W-1:0] ctrl_pick(input logic [CTRL_W-1:0] wd);
    return wd & CTRL_MASK;
  endfunction

  // Enabled status conditions, one bit each: {err, rrdy, trdy, tovr, rovr}.
  function automatic logic [4:0] cond_eval(input logic [CTRL_W-1:0] ctl,
                                           input logic rovr, input logic tovr,
                                           input logic trdy, input logic rrdy);
    logic err;
    err = rovr | tovr;
    return {err & ctl[B_IERR], rrdy & ctl[B_IRRDY], trdy & ctl[B_ITRDY],
            tovr & ctl[B_ITOVR], rovr & ctl[B_IROVR]};
  endfunction
endpackage

// File: rtl/spim_ctl_regs.sv
module spim_ctl_regs
  import spim_ctl_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2,
  parameter int NSS    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [NSS-1:0]    sel_q
);
  localparam logic [NSS-1:0] SEL_RST = NSS'(1);

  logic wr_ctrl, wr_sel;
  logic unused_wbits;
  assign wr_ctrl = host_wr && (host_addr == ADDR_W'(ADDR_CTRL));
  assign wr_sel  = host_wr && (host_addr == ADDR_W'(ADDR_SEL));
  assign unused_wbits = ^host_wdata[DATA_W-1:CTRL_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      sel_q  <= SEL_RST;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_pick(host_wdata[CTRL_W-1:0]);
      if (wr_sel)  sel_q  <= host_wdata[NSS-1:0];
    end
  end

  always_comb begin
    host_rdata = '0;
    if (host_addr == ADDR_W'(ADDR_CTRL))     host_rdata[CTRL_W-1:0] = ctrl_q;
    else if (host_addr == ADDR_W'(ADDR_SEL)) host_rdata[NSS-1:0]    = sel_q;
  end

  a_r2_ctrl_store: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> ctrl_q == ($past(host_wdata[CTRL_W-1:0]) & CTRL_MASK));
  a_r3_sel_store: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel |=> sel_q == $past(host_wdata[NSS-1:0]));
  a_r4_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(ctrl_q));
  a_r4_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sel |=> $stable(sel_q));
endmodule

// File: rtl/spim_irq_gen.sv
module spim_irq_gen
  import spim_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl_q,
  input  logic              st_rx_ovr,
  input  logic              st_tx_ovr,
  input  logic              st_tx_rdy,
  input  logic              st_rx_rdy,
  output logic              irq
);
  logic [4:0] cond_vec;
  logic       err_any;
  assign err_any  = st_rx_ovr | st_tx_ovr;
  assign cond_vec = cond_eval(ctrl_q, st_rx_ovr, st_tx_ovr, st_tx_rdy, st_rx_rdy);
  assign irq      = |cond_vec;

  a_r6_any_err: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[B_IERR] && err_any) |-> irq);
  a_r7_irq_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> |(ctrl_q & CTRL_MASK & ~(CTRL_W'(1) << B_FSEL)));
  a_r5_rrdy_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[B_IRRDY] && st_rx_rdy) |-> irq);
endmodule

// File: rtl/spim_ss_drive.sv
module spim_ss_drive #(
  parameter int NSS = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NSS-1:0] sel_q,
  input  logic           shift_busy,
  input  logic           force_sel,
  output logic [NSS-1:0] ss_n
);
  logic drive_en;
  assign drive_en = shift_busy | force_sel;

  for (genvar i = 0; i < NSS; i++) begin : g_ss
    assign ss_n[i] = ~(sel_q[i] & drive_en);
  end

  a_r8_only_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (~ss_n & ~sel_q) == '0);
  a_r10_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_busy && !force_sel) |-> &ss_n);
  a_r9_forced_low: assert property (@(posedge clk) disable iff (!rst_n)
    force_sel |-> (ss_n == ~sel_q));
endmodule

// File: rtl/spim_ctl_slice.sv
module spim_ctl_slice
  import spim_ctl_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2,
  parameter int NSS    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              st_rx_ovr,
  input  logic              st_tx_ovr,
  input  logic              st_tx_rdy,
  input  logic              st_rx_rdy,
  input  logic              shift_busy,
  output logic              irq,
  output logic [NSS-1:0]    ss_n
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [NSS-1:0]    sel_q;

  spim_ctl_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NSS(NSS)) u_regs (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .ctrl_q(ctrl_q), .sel_q(sel_q));

  spim_irq_gen u_irq (
    .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q),
    .st_rx_ovr(st_rx_ovr), .st_tx_ovr(st_tx_ovr),
    .st_tx_rdy(st_tx_rdy), .st_rx_rdy(st_rx_rdy), .irq(irq));

  spim_ss_drive #(.NSS(NSS)) u_ss (
    .clk(clk), .rst_n(rst_n), .sel_q(sel_q), .shift_busy(shift_busy),
    .force_sel(ctrl_q[B_FSEL]), .ss_n(ss_n));
endmodule

// File: tb/sim_spim_ctl_slice.sv
module sim_spim_ctl_slice;
  logic clk = 0, rst_n = 0, host_wr = 0;
  logic [1:0] host_addr = 0;
  logic [15:0] host_wdata = 0, host_rdata;
  logic rovr = 0, tovr = 0, trdy = 0, rrdy = 0, busy = 0;
  logic irq;
  logic [7:0] ss_n;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  spim_ctl_slice u0 (.clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .st_rx_ovr(rovr), .st_tx_ovr(tovr),
    .st_tx_rdy(trdy), .st_rx_rdy(rrdy), .shift_busy(busy), .irq(irq), .ss_n(ss_n));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    host_addr = a; #1; d = host_rdata;
  endtask

  task automatic stat(input logic a, input logic b, input logic c, input logic d, input logic bz);
    @(negedge clk); rovr = a; tovr = b; trdy = c; rrdy = d; busy = bz; #1;
  endtask

  // Own statement of the interrupt rule.
  function automatic logic exp_irq(input logic [15:0] c);
    logic r;
    r = 0;
    if (c[3] && rovr) r = 1;
    if (c[4] && tovr) r = 1;
    if (c[6] && trdy) r = 1;
    if (c[7] && rrdy) r = 1;
    if (c[8] && (rovr || tovr)) r = 1;
    return r;
  endfunction

  task automatic t_reset;
    logic [15:0] d;
    rd(0, d); chk("R1 ctrl", d, 0);
    rd(1, d); chk("R1 sel", d, 16'h0001);
    #1; chk("R1 irq", irq, 0); chk("R1 ss_n", ss_n, 8'hFF);
  endtask

  task automatic t_ctrl_rw;
    logic [15:0] d;
    wr(0, 16'hFFFF); rd(0, d); chk("R2 mask", d, 16'h05D8);
    wr(0, 16'h0227); rd(0, d); chk("R2 reserved", d, 16'h0000);
    wr(0, 16'h0000);
  endtask

  task automatic t_sel_rw;
    logic [15:0] d;
    wr(1, 16'hABCD); rd(1, d); chk("R3 sel", d, 16'h00CD);
  endtask

  task automatic t_isolation;
    logic [15:0] d;
    wr(0, 16'h0408);
    wr(1, 16'h0011);
    rd(0, d); chk("R4 ctrl kept", d, 16'h0408);
    wr(2, 16'hFFFF); wr(3, 16'hFFFF);
    rd(0, d); chk("R4 ctrl bad addr", d, 16'h0408);
    rd(1, d); chk("R4 sel bad addr", d, 16'h0011);
    rd(2, d); chk("R4 read bad addr", d, 0);
    repeat (3) @(negedge clk);
    rd(1, d); chk("R4 sel idle", d, 16'h0011);
    wr(0, 0);
  endtask

  task automatic t_irq_pairs;
    logic [15:0] en [4] = '{16'h0008, 16'h0010, 16'h0040, 16'h0080};
    for (int k = 0; k < 4; k++) begin
      wr(0, en[k]);
      stat(k == 0, k == 1, k == 2, k == 3, 0);
      chk($sformatf("R5 pair %0d", k), irq, 1);
      chk("R5 model", irq, exp_irq(en[k]));
      stat(k != 0, k != 1, k != 2, k != 3, 0);
      chk($sformatf("R7 other flags %0d", k), irq, exp_irq(en[k]));
    end
    stat(0, 0, 0, 0, 0); wr(0, 0);
  endtask

  task automatic t_any_err;
    wr(0, 16'h0100);
    stat(1, 0, 0, 0, 0); chk("R6 rovr", irq, 1);
    stat(0, 1, 0, 0, 0); chk("R6 tovr", irq, 1);
    stat(0, 0, 1, 1, 0); chk("R6 ready no err", irq, 0);
    stat(0, 0, 0, 0, 0); wr(0, 0);
  endtask

  task automatic t_irq_idle;
    wr(0, 16'h0000);
    stat(1, 1, 1, 1, 0); chk("R7 flags no en", irq, 0);
    wr(0, 16'h05D8);
    stat(0, 0, 0, 0, 0); chk("R7 en no flags", irq, 0);
    wr(0, 0);
  endtask

  task automatic t_ss_busy;
    wr(1, 16'h0020);
    stat(0, 0, 0, 0, 1); chk("R8 busy one", ss_n, 8'hDF);
    stat(0, 0, 0, 0, 0); chk("R10 idle", ss_n, 8'hFF);
  endtask

  task automatic t_force;
    wr(1, 16'h0081);
    wr(0, 16'h0400);
    stat(0, 0, 0, 0, 0); chk("R9 forced idle", ss_n, 8'h7E);
    wr(0, 16'h0000);
    #1; chk("R10 unforced", ss_n, 8'hFF);
  endtask

  task automatic t_multi;
    wr(1, 16'h0046);
    stat(0, 0, 0, 0, 1); chk("R11 multi", ss_n, 8'hB9);
    wr(1, 16'h0000); #1; chk("R8 empty mask", ss_n, 8'hFF);
    stat(0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ctrl_rw();
    t_sel_rw();
    t_isolation();
    t_irq_pairs();
    t_any_err();
    t_irq_idle();
    t_ss_busy();
    t_force();
    t_multi();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule